// File: doc/BRIEF.md
# Mesh Butterfly Exchange Scheduler

This block sequences the inter-element data exchanges of a 4×4 grid of processing elements that together compute a radix-4 FFT. Each element owns one butterfly stream. A single start pulse, with the transform size given as a base-4 logarithm, launches a complete transform. The block then walks every stage breadth-first: all exchange phases of one stage finish before the next stage begins. Each phase lasts exactly one butterfly time of 24 cycles.

For every cycle the scheduler tells each element whether it drives its bus, whether it captures from it, and which local output slot the word belongs to. It also reports which bus carries the traffic and which element sources each bus. Only the second stage uses the row buses and only the third uses the column buses. Every other stage reorders data locally. During those stages a bus-free flag lets external loading use the column buses.

Inside a bus phase, ownership rotates through grid positions 0 to 3 in turns of six cycles. The owner sends one complex value, as two words, to each of the three peers on its bus. The peers are visited in ascending position order, skipping the owner, and the real word goes before the imaginary word.

Top module: `ffx_exchange_sched`

## Requirements
- R1: After reset `busy_o` and `done_o` are 0, all bus enables, drive, capture and slot outputs are 0, and `bus_free_o` is 1.
- R2: A `start_i` pulse while idle is accepted only if `log4_size_i` is between 3 and 6 inclusive. Any other value leaves the block idle.
- R3: An accepted transform of size 4^m runs stages 0 to m−1 in order on `stage_o`. Each stage has 4^(m−3) phases of 24 cycles, so `busy_o` is high for exactly m·4^(m−3)·24 cycles. `done_o` is high only in the final busy cycle.
- R4: During stage 1 all four row-bus enables are 1 and all column-bus enables are 0.
- R5: During stage 2 all four column-bus enables are 1 and all row-bus enables are 0.
- R6: During any other stage, all enables, drive, capture, slot, source-select and `word_hi_o` outputs are 0 and `bus_free_o` is 1. During stages 1 and 2 `bus_free_o` is 0.
- R7: In phase cycle t (0..23), the owner position is t/6. Every enabled bus has its 2-bit source select equal to the owner and exactly one driving element.
- R8: Within an owner turn, word w = t mod 6 goes to peer k = w/2. The peer position is k when k is below the owner and k+1 otherwise. `word_hi_o` is w mod 2, so the real word (0) comes before the imaginary word (1).
- R9: The owner's slot is the peer position. The peer captures, and its slot is the owner position. All other elements neither drive nor capture and show slot 0.
- R10: A `start_i` pulse while busy is ignored and does not lengthen or restart the transform.
- R11: Element e sits at row e[3:2] and column e[1:0]. Its bit is e in `pe_drive_o` and `pe_capture_o`, and its slot is field `pe_slot_o[2e+1:2e]`. On a row bus its position is its column; on a column bus its position is its row. Row bus r and column bus c use select fields `[2r+1:2r]` and `[2c+1:2c]` of their own select outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch a transform when idle |
| log4_size_i | input | 3 | Transform size as a power of four |
| busy_o | output | 1 | Transform in progress |
| done_o | output | 1 | Final cycle of the transform |
| stage_o | output | 3 | Current stage index |
| row_bus_en_o | output | 4 | Row bus enables, one per row |
| col_bus_en_o | output | 4 | Column bus enables, one per column |
| row_src_o | output | 8 | Source position per row bus |
| col_src_o | output | 8 | Source position per column bus |
| pe_drive_o | output | 16 | Element drives its bus |
| pe_capture_o | output | 16 | Element captures from its bus |
| pe_slot_o | output | 32 | Local output slot per element |
| word_hi_o | output | 1 | Imaginary word of the current pair |
| bus_free_o | output | 1 | No exchange traffic this cycle |

## Verification
The main function is run with transform sizes 4^3, 4^4, 4^5 and 4^6. The smallest size has one phase per stage, so it isolates the stage classification and the owner rotation. The larger sizes repeat phases and add local-only stages, which exposes errors in phase counting, stage advance and the bus-free flag. Sizes 4^2 and 4^7 must be rejected. A second start pulse in mid-run shows whether the transform length stays fixed. Every busy cycle is compared against an independently enumerated sequence, so a wrong peer order, slot or driver shows up in the first cycle where it diverges.

// File: rtl/ffx_pkg.sv
package ffx_pkg;
  typedef enum logic [1:0] {
    KIND_LOCAL = 2'd0,
    KIND_ROW   = 2'd1,
    KIND_COL   = 2'd2
  } xchg_kind_e;
endpackage

// File: rtl/ffx_stage_seq.sv
module ffx_stage_seq #(
  parameter int unsigned MAX_LOG4  = 6,
  parameter int unsigned MIN_LOG4  = 3,
  parameter int unsigned PHASE_LEN = 24,
  localparam int unsigned MW = $clog2(MAX_LOG4 + 1),
  localparam int unsigned PW = 2 * (MAX_LOG4 - MIN_LOG4) + 1,
  localparam int unsigned CW = $clog2(PHASE_LEN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [MW-1:0] log4_size_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [MW-1:0] stage_o,
  output logic [CW-1:0] cyc_o
);
  logic          busy_q;
  logic [MW-1:0] m_q, stage_q;
  logic [PW-1:0] phase_q, nphase_q, nphase_d;
  logic [CW-1:0] cyc_q;
  logic          in_range, accept, last_cyc, last_phase, last_stage;

  assign in_range   = (log4_size_i >= MW'(MIN_LOG4)) && (log4_size_i <= MW'(MAX_LOG4));
  assign accept     = start_i && !busy_q && in_range;
  assign last_cyc   = (cyc_q == CW'(PHASE_LEN - 1));
  assign last_phase = (phase_q == nphase_q);
  assign last_stage = (stage_q == m_q - MW'(1));

  // phases per stage minus one: 4^(m-MIN) - 1
  always_comb begin
    int sh;
    sh = int'(log4_size_i) - int'(MIN_LOG4);
    if (sh < 0) sh = 0;
    nphase_d = PW'((1 << (2 * sh)) - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      m_q      <= '0;
      stage_q  <= '0;
      phase_q  <= '0;
      nphase_q <= '0;
      cyc_q    <= '0;
    end else if (accept) begin
      busy_q   <= 1'b1;
      m_q      <= log4_size_i;
      stage_q  <= '0;
      phase_q  <= '0;
      nphase_q <= nphase_d;
      cyc_q    <= '0;
    end else if (busy_q) begin
      if (!last_cyc) begin
        cyc_q <= cyc_q + CW'(1);
      end else begin
        cyc_q <= '0;
        if (!last_phase) begin
          phase_q <= phase_q + PW'(1);
        end else begin
          phase_q <= '0;
          if (last_stage) busy_q  <= 1'b0;
          else            stage_q <= stage_q + MW'(1);
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = busy_q && last_cyc && last_phase && last_stage;
  assign stage_o = busy_q ? stage_q : '0;
  assign cyc_o   = cyc_q;

  a_r3_done_then_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  a_r10_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);
  a_r2_reject_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i && !in_range |=> !busy_o);
  a_r3_stage_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> (stage_o == $past(stage_o)) || (stage_o == $past(stage_o) + MW'(1)));
  a_r3_cyc_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> cyc_o < CW'(PHASE_LEN));
endmodule

// File: rtl/ffx_slot_gen.sv
module ffx_slot_gen
  import ffx_pkg::*;
#(
  parameter int unsigned NR = 4,
  parameter int unsigned MW = 3,
  parameter int unsigned CW = 5,
  localparam int unsigned LN     = $clog2(NR),
  localparam int unsigned SLOT_W = 2 * (NR - 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          busy_i,
  input  logic [MW-1:0] stage_i,
  input  logic [CW-1:0] cyc_i,
  output xchg_kind_e    kind_o,
  output logic [LN-1:0] owner_o,
  output logic [LN-1:0] target_o,
  output logic          word_hi_o
);
  logic [CW-1:0] w;
  logic [LN-1:0] k;

  always_comb begin
    kind_o = KIND_LOCAL;
    if (busy_i) begin
      if (stage_i == MW'(1))      kind_o = KIND_ROW;
      else if (stage_i == MW'(2)) kind_o = KIND_COL;
    end
    owner_o   = LN'(cyc_i / CW'(SLOT_W));
    w         = cyc_i % CW'(SLOT_W);
    k         = LN'(w >> 1);
    // skip the owner's own position
    target_o  = (k < owner_o) ? k : k + LN'(1);
    word_hi_o = (kind_o != KIND_LOCAL) && w[0];
  end

  a_r8_peer_not_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_o != KIND_LOCAL |-> target_o != owner_o);
  a_r8_real_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_hi_o |-> !$past(word_hi_o) && ($past(kind_o) == kind_o));
endmodule

// File: rtl/ffx_pe_map.sv
module ffx_pe_map
  import ffx_pkg::*;
#(
  parameter int unsigned NR = 4,
  localparam int unsigned LN  = $clog2(NR),
  localparam int unsigned NPE = NR * NR
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  xchg_kind_e        kind_i,
  input  logic [LN-1:0]     owner_i,
  input  logic [LN-1:0]     target_i,
  output logic [NR-1:0]     row_en_o,
  output logic [NR-1:0]     col_en_o,
  output logic [NR*LN-1:0]  row_src_o,
  output logic [NR*LN-1:0]  col_src_o,
  output logic [NPE-1:0]    drive_o,
  output logic [NPE-1:0]    capture_o,
  output logic [NPE*LN-1:0] slot_o
);
  logic is_row, is_col, active;
  assign is_row = (kind_i == KIND_ROW);
  assign is_col = (kind_i == KIND_COL);
  assign active = is_row || is_col;

  for (genvar b = 0; b < NR; b++) begin : g_bus
    logic [NR-1:0] col_drv;
    assign row_en_o[b] = is_row;
    assign col_en_o[b] = is_col;
    assign row_src_o[b*LN +: LN] = is_row ? owner_i : '0;
    assign col_src_o[b*LN +: LN] = is_col ? owner_i : '0;
    for (genvar j = 0; j < NR; j++) begin : g_cd
      assign col_drv[j] = drive_o[j*NR + b];
    end

    a_r7_one_row_driver: assert property (@(posedge clk_i) disable iff (!rst_ni)
      row_en_o[b] |-> $countones(drive_o[b*NR +: NR]) == 1);
    a_r7_one_col_driver: assert property (@(posedge clk_i) disable iff (!rst_ni)
      col_en_o[b] |-> $countones(col_drv) == 1);
  end

  for (genvar e = 0; e < NPE; e++) begin : g_pe
    localparam int unsigned ROW = e / NR;
    localparam int unsigned COL = e % NR;
    logic [LN-1:0] pos;
    assign pos          = is_row ? LN'(COL) : LN'(ROW);
    assign drive_o[e]   = active && (pos == owner_i);
    assign capture_o[e] = active && (pos == target_i);
    assign slot_o[e*LN +: LN] = drive_o[e]   ? target_i :
                                capture_o[e] ? owner_i  : '0;

    a_r9_not_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(drive_o[e] && capture_o[e]));
  end
endmodule

// File: rtl/ffx_exchange_sched.sv
module ffx_exchange_sched
  import ffx_pkg::*;
#(
  parameter int unsigned NR       = 4,
  parameter int unsigned MAX_LOG4 = 6,
  localparam int unsigned LN        = $clog2(NR),
  localparam int unsigned NPE       = NR * NR,
  localparam int unsigned MIN_LOG4  = LN + 1,
  localparam int unsigned PHASE_LEN = 2 * NR * (NR - 1),
  localparam int unsigned MW        = $clog2(MAX_LOG4 + 1),
  localparam int unsigned CW        = $clog2(PHASE_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MW-1:0]     log4_size_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [MW-1:0]     stage_o,
  output logic [NR-1:0]     row_bus_en_o,
  output logic [NR-1:0]     col_bus_en_o,
  output logic [NR*LN-1:0]  row_src_o,
  output logic [NR*LN-1:0]  col_src_o,
  output logic [NPE-1:0]    pe_drive_o,
  output logic [NPE-1:0]    pe_capture_o,
  output logic [NPE*LN-1:0] pe_slot_o,
  output logic              word_hi_o,
  output logic              bus_free_o
);
  logic [CW-1:0] cyc;
  xchg_kind_e    kind;
  logic [LN-1:0] owner, target;

  ffx_stage_seq #(
    .MAX_LOG4 (MAX_LOG4),
    .MIN_LOG4 (MIN_LOG4),
    .PHASE_LEN(PHASE_LEN)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .log4_size_i(log4_size_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .stage_o    (stage_o),
    .cyc_o      (cyc)
  );

  ffx_slot_gen #(.NR(NR), .MW(MW), .CW(CW)) u_slot (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .busy_i   (busy_o),
    .stage_i  (stage_o),
    .cyc_i    (cyc),
    .kind_o   (kind),
    .owner_o  (owner),
    .target_o (target),
    .word_hi_o(word_hi_o)
  );

  ffx_pe_map #(.NR(NR)) u_map (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kind_i   (kind),
    .owner_i  (owner),
    .target_i (target),
    .row_en_o (row_bus_en_o),
    .col_en_o (col_bus_en_o),
    .row_src_o(row_src_o),
    .col_src_o(col_src_o),
    .drive_o  (pe_drive_o),
    .capture_o(pe_capture_o),
    .slot_o   (pe_slot_o)
  );

  assign bus_free_o = !(|row_bus_en_o || |col_bus_en_o);

  a_r6_local_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && (stage_o != MW'(1)) && (stage_o != MW'(2)) |-> bus_free_o && (pe_drive_o == '0) && (pe_capture_o == '0));
  a_r4_row_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && (stage_o == MW'(1)) |-> (&row_bus_en_o) && (col_bus_en_o == '0));
  a_r5_col_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && (stage_o == MW'(2)) |-> (&col_bus_en_o) && (row_bus_en_o == '0));
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> bus_free_o && !done_o && (pe_drive_o == '0));
endmodule

// File: tb/ffx_exchange_sched_tb.sv
`timescale 1ns/1ps
module ffx_exchange_sched_tb;
  typedef struct packed {
    logic [2:0]  stage;
    logic [3:0]  row_en;
    logic [3:0]  col_en;
    logic [7:0]  rsrc;
    logic [7:0]  csrc;
    logic [15:0] drv;
    logic [15:0] cap;
    logic [31:0] slot;
    logic        hi;
    logic        free;
    logic        done;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] lsize = '0;
  logic busy_o, done_o, word_hi_o, bus_free_o;
  logic [2:0] stage_o;
  logic [3:0] row_bus_en_o, col_bus_en_o;
  logic [7:0] row_src_o, col_src_o;
  logic [15:0] pe_drive_o, pe_capture_o;
  logic [31:0] pe_slot_o;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  item_t exp_q[$];

  always #4 clk = ~clk;

  ffx_exchange_sched u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .log4_size_i(lsize),
    .busy_o(busy_o), .done_o(done_o), .stage_o(stage_o),
    .row_bus_en_o(row_bus_en_o), .col_bus_en_o(col_bus_en_o),
    .row_src_o(row_src_o), .col_src_o(col_src_o),
    .pe_drive_o(pe_drive_o), .pe_capture_o(pe_capture_o), .pe_slot_o(pe_slot_o),
    .word_hi_o(word_hi_o), .bus_free_o(bus_free_o)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // driver: enumerate every busy cycle of a size-4^m transform
  task automatic push_run(input int m);
    int nph = 1 << (2 * (m - 3));
    for (int st = 0; st < m; st++)
      for (int ph = 0; ph < nph; ph++)
        for (int own = 0; own < 4; own++)
          for (int q = 0; q < 4; q++) begin
            if (q == own) continue;
            for (int h = 0; h < 2; h++) begin
              item_t it;
              bit rowk = (st == 1);
              bit colk = (st == 2);
              it = '0;
              it.stage = 3'(st);
              it.done = (st == m - 1) && (ph == nph - 1) && (own == 3) && (q == 2) && (h == 1);
              it.free = !(rowk || colk);
              if (rowk || colk) begin
                it.row_en = rowk ? 4'hF : 4'h0;
                it.col_en = colk ? 4'hF : 4'h0;
                it.hi = h[0];
                for (int b = 0; b < 4; b++) begin
                  if (rowk) it.rsrc[2*b +: 2] = 2'(own);
                  if (colk) it.csrc[2*b +: 2] = 2'(own);
                end
                for (int e = 0; e < 16; e++) begin
                  int pos = rowk ? (e & 3) : (e >> 2);
                  if (pos == own) begin
                    it.drv[e] = 1'b1;
                    it.slot[2*e +: 2] = 2'(q);
                  end else if (pos == q) begin
                    it.cap[e] = 1'b1;
                    it.slot[2*e +: 2] = 2'(own);
                  end
                end
              end
              exp_q.push_back(it);
            end
          end
  endtask

  function automatic string tag_of(item_t a, item_t e);
    if (a.stage !== e.stage)   return "R3 stage";
    if (a.done !== e.done)     return "R3 done";
    if (a.row_en !== e.row_en) return "R4 row enables";
    if (a.col_en !== e.col_en) return "R5 column enables";
    if (a.free !== e.free)     return "R6 bus free";
    if (a.rsrc !== e.rsrc || a.csrc !== e.csrc) return "R7 source select";
    if (a.drv !== e.drv)       return "R7 R11 drivers";
    if (a.hi !== e.hi)         return "R8 word order";
    if (a.cap !== e.cap)       return "R9 R11 captures";
    return "R9 slots";
  endfunction

  // monitor: pop one expected item per busy cycle
  always @(negedge clk) begin
    item_t a, e;
    if (rst_n && busy_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10", "busy beyond expected length", 64'(busy_o), 64'd0);
      end else begin
        e = exp_q.pop_front();
        a = '{stage: stage_o, row_en: row_bus_en_o, col_en: col_bus_en_o,
              rsrc: row_src_o, csrc: col_src_o, drv: pe_drive_o, cap: pe_capture_o,
              slot: pe_slot_o, hi: word_hi_o, free: bus_free_o, done: done_o};
        check(a === e, tag_of(a, e), "cycle", 64'(a.drv) | (64'(a.stage) << 48),
              64'(e.drv) | (64'(e.stage) << 48));
      end
    end
  end

  task automatic pulse_start(input int m);
    @(negedge clk);
    start = 1'b1;
    lsize = 3'(m);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_case(input int m, input bit mid_pulse);
    push_run(m);
    pulse_start(m);
    if (mid_pulse) begin
      repeat (50) @(negedge clk);
      pulse_start(3);  // R10: ignored while busy
    end
    do @(posedge clk); while (exp_q.size() != 0);
    @(negedge clk);
    check(busy_o == 1'b0, mid_pulse ? "R10" : "R3", "idle after final cycle", 64'(busy_o), 64'd0);
    check(bus_free_o == 1'b1, "R6", "bus free when idle", 64'(bus_free_o), 64'd1);
  endtask

  task automatic try_reject(input int m);
    pulse_start(m);
    repeat (3) @(negedge clk);
    check(busy_o == 1'b0, "R2", "out-of-range size rejected", 64'(busy_o), 64'd0);
    check(pe_drive_o == '0, "R2", "no drivers after reject", 64'(pe_drive_o), 64'd0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy_o == 1'b0, "R1", "busy in reset", 64'(busy_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_o == 1'b0 && done_o == 1'b0, "R1", "busy/done after reset", 64'({busy_o, done_o}), 64'd0);
    check(row_bus_en_o == '0 && col_bus_en_o == '0, "R1", "enables after reset",
          64'({row_bus_en_o, col_bus_en_o}), 64'd0);
    check(pe_drive_o == '0 && pe_capture_o == '0 && pe_slot_o == '0, "R1", "element outputs after reset",
          64'(pe_drive_o), 64'd0);
    check(bus_free_o == 1'b1, "R1", "bus free after reset", 64'(bus_free_o), 64'd1);

    try_reject(2);
    try_reject(7);
    run_case(3, 1'b0);
    run_case(4, 1'b1);
    run_case(5, 1'b0);
    run_case(6, 1'b0);
    try_reject(0);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      summary();
    end
  end
endmodule